// File: doc/BRIEF.md
# Instruction Prefix Operand-Size and Segment Resolver

This block sits behind a prefix splitter in an instruction decoder. For one instruction it takes flags for the prefix bytes that were seen, the current execution mode and a few hints about the instruction's class. From these it settles three things: the effective operand size, the segment that the data reference uses, and whether a register-extension prefix takes part in decode. Opcode decoding and address-size resolution happen elsewhere.

In 64-bit mode the block applies that mode's rules. The operand size defaults to 32 bits. The width bit of the extension prefix forces 64 bits and wins over the operand-size byte (66h). Near branches, and stack-implicit instructions other than far branches, default to 64 bits. The ES, CS, SS and DS overrides become null prefixes, while FS and GS still add their base. In other modes the extension prefix is never recognised, all six overrides act normally, and 66h switches the size between 16 and 32 bits relative to a default given on an input.

Requests enter on a valid/ready handshake and results leave on another. The request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). A result the consumer has not taken stays held, and while it is held no new request is accepted.

Top module: `pfx_resolver`

## Requirements
- R1: A request accepted at a clock edge appears on the outputs with `out_valid` high after that edge, so the latency is one cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every result output holds its value.
- R2: In 64-bit mode (`mode64`=1), with no width bit, no 66h and no forcing class, `osize` is 32 bits. The `osize` encoding is 0 for 16 bits, 1 for 32 bits and 2 for 64 bits.
- R3: In 64-bit mode, an extension prefix with its width bit set gives 64 bits, whether or not 66h is present.
- R4: In 64-bit mode, 66h without an effective width bit gives 16 bits, including on near-branch and stack-implicit instructions.
- R5: In 64-bit mode, a near branch gives 64 bits without an extension prefix. So does a stack-implicit instruction that is not a far branch. A far branch with stack use keeps the 32-bit default.
- R6: In 64-bit mode, an effective override of ES(0), CS(1), SS(2) or DS(3) yields `seg_sel`=7 (no override) and `seg_base_add`=0.
- R7: In 64-bit mode, an effective override of FS(4) or GS(5) yields that code on `seg_sel` with `seg_base_add`=1.
- R8: `last_seg` names the override that came last in prefix order, and only that one is considered. It is effective only if it is below 6 and its bit in `seg_present` (bit index = code) is set. Otherwise `seg_sel`=7 and `seg_base_add`=0.
- R9: In 64-bit mode `rex_ignored` is 1 exactly when the extension prefix is present but neither `ext_reg` nor its width bit is set. Without the prefix it is 0.
- R10: Outside 64-bit mode, `rex_ignored` equals `rex_present` and the width bit has no effect. 66h toggles the size between 16 and 32 bits against `legacy_def32` (1 = 32-bit default). An effective override of any of the six segments is selected with `seg_base_add`=1.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| mode64 | input | 1 | 1 = 64-bit mode |
| legacy_def32 | input | 1 | Default size outside 64-bit mode: 1 = 32, 0 = 16 |
| rex_present | input | 1 | Register-extension prefix seen |
| rex_w | input | 1 | Width bit of that prefix |
| opsz_present | input | 1 | 66h prefix seen |
| seg_present | input | 6 | Override seen, bit index = segment code |
| last_seg | input | 3 | Code of the last override in prefix order |
| near_branch | input | 1 | Instruction is a near branch |
| stack_implicit | input | 1 | Instruction uses the stack pointer implicitly |
| far_branch | input | 1 | Instruction is a far branch |
| ext_reg | input | 1 | Instruction names an extended register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| osize | output | 2 | Operand size: 0 = 16, 1 = 32, 2 = 64 |
| seg_sel | output | 3 | Segment code 0..5, 7 = no override |
| seg_base_add | output | 1 | Segment base joins the address |
| rex_ignored | output | 1 | Extension prefix had no effect |

## Verification
Some rules are checked by assertions on every cycle. These are the handshake rules: the one-cycle latency and the held result under back-pressure. They also cover the width bit forcing 64 bits, the four null overrides in 64-bit mode, the absence of 64-bit sizing outside that mode, and the agreement between `seg_base_add` and `seg_sel`. Other rules can only be shown by the bench's directed and random scenarios: the 16-bit result from 66h on forced-64 classes, the far-branch exception, last-override selection against absent bits, and the legacy toggle against the mode default.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int SEG_W    = 3;
  localparam int NUM_SEG  = 6;
  localparam int NUM_NULL = 4;  // codes below this are null overrides in 64-bit mode
  localparam logic [SEG_W-1:0] SEG_NONE = 3'd7;

  typedef enum logic [1:0] {
    OSZ_16 = 2'd0,
    OSZ_32 = 2'd1,
    OSZ_64 = 2'd2
  } osz_e;

  typedef struct packed {
    osz_e             osz;
    logic [SEG_W-1:0] seg;
    logic             base_add;
    logic             rex_ign;
  } pfx_res_t;

  localparam int RES_W = $bits(pfx_res_t);
endpackage

// File: rtl/pfx_opsize.sv
module pfx_opsize
  import pfx_pkg::*;
(
  input  logic mode64,
  input  logic legacy_def32,
  input  logic rex_present,
  input  logic rex_w,
  input  logic opsz_present,
  input  logic near_branch,
  input  logic stack_implicit,
  input  logic far_branch,
  input  logic ext_reg,
  output osz_e osz,
  output logic rex_ign
);
  logic rex_live;
  logic wide_req;
  logic force64;

  // prefix recognised only in 64-bit mode
  assign rex_live = mode64 & rex_present;
  assign wide_req = rex_live & rex_w;
  assign force64  = near_branch | (stack_implicit & ~far_branch);
  assign rex_ign  = rex_present & ~(rex_live & (ext_reg | rex_w));

  always_comb begin
    if (!mode64) begin
      if (legacy_def32 ^ opsz_present) osz = OSZ_32;
      else                             osz = OSZ_16;
    end else if (wide_req) begin
      osz = OSZ_64;
    end else if (opsz_present) begin
      osz = OSZ_16;
    end else if (force64) begin
      osz = OSZ_64;
    end else begin
      osz = OSZ_32;
    end
  end
endmodule

// File: rtl/pfx_segsel.sv
module pfx_segsel
  import pfx_pkg::*;
#(
  parameter int NSEG  = NUM_SEG,
  parameter int NNULL = NUM_NULL
) (
  input  logic              mode64,
  input  logic [NSEG-1:0]   seg_present,
  input  logic [SEG_W-1:0]  last_seg,
  output logic [SEG_W-1:0]  seg,
  output logic              base_add
);
  logic [NSEG-1:0] hit;
  logic [NSEG-1:0] keep;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign hit[i] = seg_present[i] && (last_seg == SEG_W'(i));
    if (i < NNULL) begin : g_nullable
      assign keep[i] = hit[i] & ~mode64;
    end else begin : g_live
      assign keep[i] = hit[i];
    end
  end

  always_comb begin
    seg = SEG_NONE;
    for (int j = 0; j < NSEG; j++) begin
      if (keep[j]) seg = SEG_W'(j);
    end
  end

  assign base_add = |keep;
endmodule

// File: rtl/pfx_outreg.sv
module pfx_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfx_resolver.sv
module pfx_resolver
  import pfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               mode64,
  input  logic               legacy_def32,
  input  logic               rex_present,
  input  logic               rex_w,
  input  logic               opsz_present,
  input  logic [NUM_SEG-1:0] seg_present,
  input  logic [SEG_W-1:0]   last_seg,
  input  logic               near_branch,
  input  logic               stack_implicit,
  input  logic               far_branch,
  input  logic               ext_reg,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         osize,
  output logic [SEG_W-1:0]   seg_sel,
  output logic               seg_base_add,
  output logic               rex_ignored
);
  pfx_res_t nxt;
  pfx_res_t cur;
  logic [RES_W-1:0] cur_bits;

  pfx_opsize u_osz (
    .mode64         (mode64),
    .legacy_def32   (legacy_def32),
    .rex_present    (rex_present),
    .rex_w          (rex_w),
    .opsz_present   (opsz_present),
    .near_branch    (near_branch),
    .stack_implicit (stack_implicit),
    .far_branch     (far_branch),
    .ext_reg        (ext_reg),
    .osz            (nxt.osz),
    .rex_ign        (nxt.rex_ign)
  );

  pfx_segsel #(.NSEG(NUM_SEG), .NNULL(NUM_NULL)) u_seg (
    .mode64      (mode64),
    .seg_present (seg_present),
    .last_seg    (last_seg),
    .seg         (nxt.seg),
    .base_add    (nxt.base_add)
  );

  pfx_outreg #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (cur_bits)
  );

  assign cur          = pfx_res_t'(cur_bits);
  assign osize        = cur.osz;
  assign seg_sel      = cur.seg;
  assign seg_base_add = cur.base_add;
  assign rex_ignored  = cur.rex_ign;
endmodule

// File: rtl/pfx_resolver_chk.sv
module pfx_resolver_chk
  import pfx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               mode64,
  input logic               rex_present,
  input logic               rex_w,
  input logic [SEG_W-1:0]   last_seg,
  input logic               out_valid,
  input logic               out_ready,
  input logic [1:0]         osize,
  input logic [SEG_W-1:0]   seg_sel,
  input logic               seg_base_add,
  input logic               rex_ignored
);
  logic acc;
  assign acc = in_valid & in_ready;

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(osize) && $stable(seg_sel)
                                   && $stable(seg_base_add) && $stable(rex_ignored)));

  a_r3_width_forces_64: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode64 && rex_present && rex_w) |=> (osize == 2'd2 && !rex_ignored));

  a_r6_null_override: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode64 && last_seg < 3'd4) |=> (seg_sel == SEG_NONE && !seg_base_add));

  a_r7_base_has_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seg_base_add) |-> (seg_sel != SEG_NONE));

  a_r10_legacy_no64: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mode64) |=> (osize != 2'd2 && rex_ignored == $past(rex_present)));
endmodule

bind pfx_resolver pfx_resolver_chk u_chk (.*);

// File: tb/tb_pfx_resolver.sv
`timescale 1ns/1ps
module tb_pfx_resolver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready;
  logic       mode64, legacy_def32, rex_present, rex_w, opsz_present;
  logic [5:0] seg_present;
  logic [2:0] last_seg;
  logic       near_branch, stack_implicit, far_branch, ext_reg;
  logic       out_valid, out_ready;
  logic [1:0] osize;
  logic [2:0] seg_sel;
  logic       seg_base_add, rex_ignored;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfx_resolver dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_osz();
    if (!mode64) return (legacy_def32 ^ opsz_present) ? 1 : 0;
    if (rex_present && rex_w) return 2;
    if (opsz_present) return 0;
    if (near_branch || (stack_implicit && !far_branch)) return 2;
    return 1;
  endfunction

  function automatic string osz_tag();
    if (!mode64) return "R10";
    if (rex_present && rex_w) return "R3";
    if (opsz_present) return "R4";
    if (near_branch || stack_implicit) return "R5";
    return "R2";
  endfunction

  function automatic bit ref_eff();
    return (last_seg < 3'd6) && seg_present[last_seg];
  endfunction

  function automatic int ref_seg();
    if (!ref_eff()) return 7;
    if (mode64 && last_seg < 3'd4) return 7;
    return int'(last_seg);
  endfunction

  function automatic string seg_tag();
    if (!ref_eff()) return "R8";
    if (!mode64) return "R10";
    if (last_seg < 3'd4) return "R6";
    return "R7";
  endfunction

  function automatic int ref_ign();
    return int'(rex_present && !(mode64 && (ext_reg || rex_w)));
  endfunction

  // drive at negedge, accept at posedge, check at following negedge
  task automatic run_one(input bit stall);
    string st, tg;
    int eo, es, eb, ei;
    eo = ref_osz(); es = ref_seg(); eb = (es != 7) ? 1 : 0; ei = ref_ign();
    st = osz_tag(); tg = seg_tag();
    chk("R1", int'(in_ready), 1);
    in_valid  = 1'b1;
    out_ready = !stall;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", int'(out_valid), 1);
    chk(st, int'(osize), eo);
    chk(tg, int'(seg_sel), es);
    chk(tg, int'(seg_base_add), eb);
    chk(mode64 ? "R9" : "R10", int'(rex_ignored), ei);
    if (stall) begin
      chk("R1", int'(in_ready), 0);
      @(negedge clk);
      chk("R1", int'(out_valid), 1);
      chk("R1", int'(osize), eo);
      chk("R1", int'(seg_sel), es);
      out_ready = 1'b1;
    end
    @(negedge clk);
    chk("R1", int'(out_valid), 0);
  endtask

  task automatic set_in(input bit m, input bit d32, input bit rx, input bit w,
                        input bit o, input logic [5:0] sp, input logic [2:0] ls,
                        input bit nb, input bit si, input bit fb, input bit er);
    mode64 = m; legacy_def32 = d32; rex_present = rx; rex_w = w; opsz_present = o;
    seg_present = sp; last_seg = ls; near_branch = nb; stack_implicit = si;
    far_branch = fb; ext_reg = er;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    set_in(0,0,0,0,0,6'd0,3'd7,0,0,0,0);
    repeat (3) @(negedge clk);
    chk("R11", int'(out_valid), 0);
    chk("R11", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", int'(out_valid), 0);

    // directed corners
    set_in(1,0,0,0,0,6'd0,3'd7,0,0,0,0); run_one(0);        // R2 default 32
    set_in(1,0,1,1,1,6'd0,3'd7,0,0,0,0); run_one(0);        // R3 W beats 66h
    set_in(1,0,0,0,1,6'd0,3'd7,1,0,0,0); run_one(0);        // R4 66h on near branch
    set_in(1,0,0,0,0,6'd0,3'd7,1,0,0,0); run_one(0);        // R5 near branch
    set_in(1,0,0,0,0,6'd0,3'd7,0,1,0,0); run_one(0);        // R5 stack implicit
    set_in(1,0,0,0,0,6'd0,3'd7,0,1,1,0); run_one(0);        // R5 far branch stays 32
    set_in(1,0,0,0,0,6'b001000,3'd3,0,0,0,0); run_one(1);   // R6 DS null, stalled
    set_in(1,0,0,0,0,6'b000010,3'd1,0,0,0,0); run_one(0);   // R6 CS null
    set_in(1,0,0,0,0,6'b110000,3'd5,0,0,0,0); run_one(0);   // R7 GS last
    set_in(1,0,0,0,0,6'b010001,3'd4,0,0,0,0); run_one(0);   // R7 FS last
    set_in(1,0,0,0,0,6'b100000,3'd4,0,0,0,0); run_one(0);   // R8 last not present
    set_in(0,1,0,0,0,6'b111111,3'd6,0,0,0,0); run_one(0);   // R8 code 6
    set_in(1,0,1,0,0,6'd0,3'd7,0,0,0,0); run_one(0);        // R9 ignored
    set_in(1,0,1,0,0,6'd0,3'd7,0,0,0,1); run_one(0);        // R9 used by ext reg
    set_in(0,1,1,1,0,6'b000100,3'd2,0,0,0,1); run_one(0);   // R10 W no effect, SS live
    set_in(0,0,0,0,1,6'b000001,3'd0,1,1,0,0); run_one(1);   // R10 toggle to 32
    set_in(0,1,0,0,1,6'd0,3'd7,0,0,0,0); run_one(0);        // R10 toggle to 16

    for (int k = 0; k < 600; k++) begin
      set_in(($urandom % 4) != 0, $urandom, $urandom, $urandom, $urandom,
             6'($urandom), 3'($urandom), $urandom, $urandom, $urandom, $urandom);
      run_one(($urandom % 3) == 0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule